// File: doc/BRIEF.md
# Multi-Dimensional Register Index Remapper

This block turns a linear element position into an index within a three-dimensional array whose dimensions are walked in an order chosen at run time. A packed shape word gives the three dimension sizes, three offset flags and a permutation code. On a start pulse the block steps through 128 element positions, one per cycle. Each position yields one 8-bit index, which is stored in an internal table that the element loop outside the block reads through a combinational read port.

A second word binds up to three register numbers to the shape. A combinational lookup takes a register number and a privilege mode and reports whether the shape applies, and through which slot. Remapping applies only in user mode and never to register 0.

The control is a four-state machine. `WALK_IDLE` waits for a start pulse. An accepted start with a legal permutation code takes the `idle->run` transition. An illegal code takes `idle->fault`. `WALK_RUN` writes one table entry per cycle. After the last entry it takes `run->finish`. `WALK_FINISH` raises the done pulse and `WALK_FAULT` raises the illegal pulse. Both leave unconditionally through `finish->idle` and `fault->idle`.

Top module: `shape_remap`

## Requirements
- R1: After reset, busy, done and illegal are low, every table entry reads 0, the offset flags read 0 and the lookup reports no hit.
- R2: The shape word holds the X size field in bits [6:0], the Y size field in bits [14:8], the Z size field in bits [22:16] and the permutation code in bits [26:24]. Each dimension size equals its field value plus one.
- R3: The permutation codes are 0=XYZ, 1=XZY, 2=YXZ, 3=YZX, 4=ZXY and 5=ZYX. The first dimension named steps fastest, and the last steps slowest.
- R4: Each table entry equals x + y*xsize + z*xsize*ysize, truncated to 8 bits.
- R5: Exactly 128 entries are written, starting from x=y=z=0. After each entry the fastest dimension increments. A dimension that reaches its size returns to 0 and carries into the next dimension in permutation order. When all three carry out together, the counters wrap to zero and generation continues.
- R6: A start carrying permutation code 6 or 7 raises illegal for exactly one cycle, starting the cycle after start. Busy stays low, and the table and offset flags are left unchanged.
- R7: After a legal start, busy is high for exactly 128 cycles, beginning the cycle after start. Done is high for exactly one cycle, in the cycle after busy falls.
- R8: A start pulse that arrives while busy is high is ignored. The table ends up holding the first shape's sequence.
- R9: On an accepted legal start, offs_o[0], offs_o[1] and offs_o[2] take shape word bits 7, 15 and 23. They hold those values until the next accepted start.
- R10: The lookup reports no hit when the mode is not user. The mode encodings are 0=user, 1=supervisor and 3=machine, and 2 is also treated as non-user. It also reports no hit when the looked-up register number is 0.
- R11: The remap word holds slot 0 in bits [6:0], slot 1 in bits [13:7] and slot 2 in bits [20:14]. In user mode with a nonzero register number, the lookup returns hit=1 and the lowest-numbered slot whose register number matches. If no slot matches, it returns hit=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a table walk using shape_cfg_i |
| shape_cfg_i | input | 27 | Packed shape word: sizes, offset flags, permutation code |
| remap_cfg_i | input | 21 | Three register-number slots |
| rd_addr_i | input | 7 | Table read address |
| rd_data_o | output | 8 | Table entry at rd_addr_i |
| busy_o | output | 1 | High while entries are being written |
| done_o | output | 1 | One-cycle pulse after the last entry |
| illegal_o | output | 1 | One-cycle pulse for a rejected permutation code |
| offs_o | output | 3 | Offset flags of the last accepted shape |
| lk_reg_i | input | 7 | Register number to look up |
| lk_mode_i | input | 2 | Privilege mode of the lookup |
| lk_hit_o | output | 1 | A remap slot applies |
| lk_slot_o | output | 2 | Index of the matching slot |

## Verification
The bench builds the block with its default parameters: 128 entries, 7-bit size fields, 8-bit indices, 7-bit register numbers and three slots. With these values, a size field of 127 is reachable. The bench uses it to push y*xsize past 255, which exposes the 8-bit truncation. Small shapes such as 2x2x2 carry out of all three dimensions many times within 128 entries, so the wrap-to-zero path is exercised repeatedly. Every one of the six orders is walked on the same asymmetric 3x4x2 shape, so a swapped order shows up as a different sequence.

// File: rtl/shape_remap_pkg.sv
package shape_remap_pkg;

    // Dimension selectors used inside an iteration order
    typedef logic [1:0] dim_sel_t;
    localparam dim_sel_t DIM_X = 2'd0;
    localparam dim_sel_t DIM_Y = 2'd1;
    localparam dim_sel_t DIM_Z = 2'd2;

    // Order: element 0 steps fastest, element 2 slowest
    typedef dim_sel_t [2:0] order_t;

    // Permutation codes carried in the shape word
    typedef enum logic [2:0] {
        PERM_XYZ = 3'd0,
        PERM_XZY = 3'd1,
        PERM_YXZ = 3'd2,
        PERM_YZX = 3'd3,
        PERM_ZXY = 3'd4,
        PERM_ZYX = 3'd5
    } perm_code_e;

    localparam int PERM_W = 3;

    // Privilege mode in which remapping is active
    localparam logic [1:0] PRIV_USER = 2'd0;

    // Walk controller states
    typedef enum logic [1:0] {
        WALK_IDLE   = 2'd0,
        WALK_RUN    = 2'd1,
        WALK_FINISH = 2'd2,
        WALK_FAULT  = 2'd3
    } walk_state_e;

endpackage

// File: rtl/shape_field_decode.sv
module shape_field_decode
    import shape_remap_pkg::*;
#(
    parameter int DIM_W = 7
) (
    input  logic [3*(DIM_W+1)+PERM_W-1:0] shape_i,
    output logic [2:0][DIM_W:0]           size_o,
    output logic [2:0]                    offs_o,
    output order_t                        order_o,
    output logic                          legal_o
);

    localparam int LANE_W = DIM_W + 1;

    logic [PERM_W-1:0] perm_code;

    assign perm_code = shape_i[3*LANE_W +: PERM_W];

    // One lane per dimension: size field then an offset flag on top
    for (genvar d = 0; d < 3; d++) begin : g_lane
        assign size_o[d] = {1'b0, shape_i[d*LANE_W +: DIM_W]} + LANE_W'(1);
        assign offs_o[d] = shape_i[d*LANE_W + DIM_W];
    end

    always_comb begin
        legal_o = 1'b1;
        order_o = {DIM_Z, DIM_Y, DIM_X};
        case (perm_code)
            PERM_XYZ: order_o = {DIM_Z, DIM_Y, DIM_X};
            PERM_XZY: order_o = {DIM_Y, DIM_Z, DIM_X};
            PERM_YXZ: order_o = {DIM_Z, DIM_X, DIM_Y};
            PERM_YZX: order_o = {DIM_X, DIM_Z, DIM_Y};
            PERM_ZXY: order_o = {DIM_Y, DIM_X, DIM_Z};
            PERM_ZYX: order_o = {DIM_X, DIM_Y, DIM_Z};
            default:  legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/shape_index_walker.sv
module shape_index_walker
    import shape_remap_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int DIM_W   = 7,
    parameter int IDX_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       legal_i,
    input  logic [2:0][DIM_W:0]        size_i,
    input  order_t                     order_i,
    input  logic [2:0]                 offs_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic                       illegal_o,
    output logic [2:0]                 offs_o,
    output logic                       wr_en_o,
    output logic [$clog2(ENTRIES)-1:0] wr_addr_o,
    output logic [IDX_W-1:0]           wr_data_o
);

    localparam int LANE_W = DIM_W + 1;
    localparam int ADDR_W = $clog2(ENTRIES);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(ENTRIES - 1);

    walk_state_e state_q, state_d;

    logic [2:0][LANE_W-1:0] lim_q;
    logic [2:0][LANE_W-1:0] ctr_q, ctr_d;
    order_t                 ord_q;
    logic [2:0]             offs_q;
    logic [ADDR_W-1:0]      pos_q;
    logic                   accept;
    logic                   reject;

    assign accept = (state_q == WALK_IDLE) && start_i && legal_i;
    assign reject = (state_q == WALK_IDLE) && start_i && !legal_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WALK_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WALK_IDLE: begin
                if (accept)      state_d = WALK_RUN;
                else if (reject) state_d = WALK_FAULT;
            end
            WALK_RUN: begin
                if (pos_q == LAST_ADDR) state_d = WALK_FINISH;
            end
            WALK_FINISH: state_d = WALK_IDLE;
            WALK_FAULT:  state_d = WALK_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        busy_o    = 1'b0;
        done_o    = 1'b0;
        illegal_o = 1'b0;
        wr_en_o   = 1'b0;
        unique case (state_q)
            WALK_IDLE:   ;
            WALK_RUN:    begin busy_o = 1'b1; wr_en_o = 1'b1; end
            WALK_FINISH: done_o = 1'b1;
            WALK_FAULT:  illegal_o = 1'b1;
        endcase
    end

    // Carry chain walked in permutation order
    always_comb begin
        logic carry;
        logic [LANE_W-1:0] bumped;
        ctr_d = ctr_q;
        carry = 1'b1;
        for (int j = 0; j < 3; j++) begin
            if (carry) begin
                bumped = ctr_q[ord_q[j]] + LANE_W'(1);
                if (bumped == lim_q[ord_q[j]]) begin
                    ctr_d[ord_q[j]] = '0;
                end else begin
                    ctr_d[ord_q[j]] = bumped;
                    carry = 1'b0;
                end
            end
        end
    end

    // Linear index, kept in IDX_W bits throughout
    always_comb begin
        wr_data_o = IDX_W'(ctr_q[0])
                  + IDX_W'(ctr_q[1]) * IDX_W'(lim_q[0])
                  + IDX_W'(ctr_q[2]) * IDX_W'(lim_q[0]) * IDX_W'(lim_q[1]);
    end

    assign wr_addr_o = pos_q;
    assign offs_o    = offs_q;

    // Shape capture and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q  <= '0;
            ctr_q  <= '0;
            ord_q  <= {DIM_Z, DIM_Y, DIM_X};
            offs_q <= '0;
            pos_q  <= '0;
        end else if (accept) begin
            lim_q  <= size_i;
            ord_q  <= order_i;
            offs_q <= offs_i;
            ctr_q  <= '0;
            pos_q  <= '0;
        end else if (state_q == WALK_RUN) begin
            ctr_q  <= ctr_d;
            pos_q  <= pos_q + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/shape_remap_lookup.sv
module shape_remap_lookup
    import shape_remap_pkg::*;
#(
    parameter int REG_W = 7,
    parameter int SLOTS = 3
) (
    input  logic [SLOTS*REG_W-1:0]   remap_i,
    input  logic [REG_W-1:0]         reg_i,
    input  logic [1:0]               mode_i,
    output logic                     hit_o,
    output logic [$clog2(SLOTS)-1:0] slot_o
);

    localparam int SLOT_W = $clog2(SLOTS);

    logic [SLOTS-1:0] match;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign match[s] = (remap_i[s*REG_W +: REG_W] == reg_i);
    end

    // Highest index first so that the lowest matching slot wins
    always_comb begin
        hit_o  = 1'b0;
        slot_o = '0;
        if (mode_i == PRIV_USER && reg_i != '0) begin
            for (int s = SLOTS - 1; s >= 0; s--) begin
                if (match[s]) begin
                    hit_o  = 1'b1;
                    slot_o = SLOT_W'(s);
                end
            end
        end
    end

endmodule

// File: rtl/shape_remap.sv
module shape_remap
    import shape_remap_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int DIM_W   = 7,
    parameter int IDX_W   = 8,
    parameter int REG_W   = 7,
    parameter int SLOTS   = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start_i,
    input  logic [3*(DIM_W+1)+PERM_W-1:0]       shape_cfg_i,
    input  logic [SLOTS*REG_W-1:0]              remap_cfg_i,
    input  logic [$clog2(ENTRIES)-1:0]          rd_addr_i,
    output logic [IDX_W-1:0]                    rd_data_o,
    output logic                                busy_o,
    output logic                                done_o,
    output logic                                illegal_o,
    output logic [2:0]                          offs_o,
    input  logic [REG_W-1:0]                    lk_reg_i,
    input  logic [1:0]                          lk_mode_i,
    output logic                                lk_hit_o,
    output logic [$clog2(SLOTS)-1:0]            lk_slot_o
);

    localparam int ADDR_W = $clog2(ENTRIES);

    logic [2:0][DIM_W:0] dec_size;
    logic [2:0]          dec_offs;
    order_t              dec_order;
    logic                dec_legal;

    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic [IDX_W-1:0]    wr_data;

    logic [IDX_W-1:0]    table_q [ENTRIES];

    shape_field_decode #(
        .DIM_W (DIM_W)
    ) u_decode (
        .shape_i (shape_cfg_i),
        .size_o  (dec_size),
        .offs_o  (dec_offs),
        .order_o (dec_order),
        .legal_o (dec_legal)
    );

    shape_index_walker #(
        .ENTRIES (ENTRIES),
        .DIM_W   (DIM_W),
        .IDX_W   (IDX_W)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .legal_i   (dec_legal),
        .size_i    (dec_size),
        .order_i   (dec_order),
        .offs_i    (dec_offs),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .illegal_o (illegal_o),
        .offs_o    (offs_o),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    shape_remap_lookup #(
        .REG_W (REG_W),
        .SLOTS (SLOTS)
    ) u_lookup (
        .remap_i (remap_cfg_i),
        .reg_i   (lk_reg_i),
        .mode_i  (lk_mode_i),
        .hit_o   (lk_hit_o),
        .slot_o  (lk_slot_o)
    );

    // Index table
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) table_q[i] <= '0;
        end else if (wr_en) begin
            table_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data_o = table_q[rd_addr_i];

endmodule

// File: rtl/shape_remap_chk.sv
module shape_remap_chk #(
    parameter int ENTRIES = 128,
    parameter int IDX_W   = 8,
    parameter int REG_W   = 7
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start_i,
    input logic                       busy_o,
    input logic                       done_o,
    input logic                       illegal_o,
    input logic [$clog2(ENTRIES)-1:0] rd_addr_i,
    input logic [IDX_W-1:0]           rd_data_o,
    input logic [REG_W-1:0]           lk_reg_i,
    input logic [1:0]                 lk_mode_i,
    input logic                       lk_hit_o
);

    // Length of the current busy run, counted outside the design
    logic [31:0] run_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_len <= '0;
        else if (busy_o) run_len <= run_len + 32'd1;
        else             run_len <= '0;
    end

    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 32'(ENTRIES));

    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_fault_no_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!busy_o && !done_o));

    p_fault_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> (!illegal_o && !busy_o));

    p_table_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy_o) && $stable(rd_addr_i)) |-> $stable(rd_data_o));

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    p_priv_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_mode_i != 2'd0) |-> !lk_hit_o);

    p_reg_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_reg_i == '0) |-> !lk_hit_o);

endmodule

bind shape_remap shape_remap_chk #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .REG_W   (REG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .illegal_o (illegal_o),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .lk_reg_i  (lk_reg_i),
    .lk_mode_i (lk_mode_i),
    .lk_hit_o  (lk_hit_o)
);

// File: tb/shape_remap_tb.sv
module shape_remap_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [26:0] shape_cfg_i = '0;
    logic [20:0] remap_cfg_i = '0;
    logic [6:0]  rd_addr_i = '0;
    logic [7:0]  rd_data_o;
    logic        busy_o, done_o, illegal_o;
    logic [2:0]  offs_o;
    logic [6:0]  lk_reg_i = '0;
    logic [1:0]  lk_mode_i = 2'd0;
    logic        lk_hit_o;
    logic [1:0]  lk_slot_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_tab [128];

    always #4 clk = ~clk;

    shape_remap u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .shape_cfg_i (shape_cfg_i),
        .remap_cfg_i (remap_cfg_i),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_data_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .illegal_o   (illegal_o),
        .offs_o      (offs_o),
        .lk_reg_i    (lk_reg_i),
        .lk_mode_i   (lk_mode_i),
        .lk_hit_o    (lk_hit_o),
        .lk_slot_o   (lk_slot_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [26:0] mk(input int xf, input int yf, input int zf,
                                       input logic [2:0] ob, input int perm);
        return {3'(perm), ob[2], 7'(zf), ob[1], 7'(yf), ob[0], 7'(xf)};
    endfunction

    // Reference sequence built from the stated stepping rules
    function automatic void build_exp(input int xs, input int ys, input int zs,
                                      input int perm);
        int lim [3];
        int c   [3];
        int ord [3];
        lim[0] = xs; lim[1] = ys; lim[2] = zs;
        c[0] = 0; c[1] = 0; c[2] = 0;
        case (perm)
            0: begin ord[0] = 0; ord[1] = 1; ord[2] = 2; end
            1: begin ord[0] = 0; ord[1] = 2; ord[2] = 1; end
            2: begin ord[0] = 1; ord[1] = 0; ord[2] = 2; end
            3: begin ord[0] = 1; ord[1] = 2; ord[2] = 0; end
            4: begin ord[0] = 2; ord[1] = 0; ord[2] = 1; end
            default: begin ord[0] = 2; ord[1] = 1; ord[2] = 0; end
        endcase
        for (int i = 0; i < 128; i++) begin
            exp_tab[i] = 8'(c[0] + c[1] * xs + c[2] * xs * ys);
            for (int j = 0; j < 3; j++) begin
                c[ord[j]] = c[ord[j]] + 1;
                if (c[ord[j]] != lim[ord[j]]) break;
                c[ord[j]] = 0;
            end
        end
    endfunction

    task automatic compare_table(input string req);
        for (int i = 0; i < 128; i++) begin
            rd_addr_i = 7'(i);
            @(negedge clk);
            chk(rd_data_o == exp_tab[i], req, $sformatf("entry %0d", i),
                rd_data_o, exp_tab[i]);
        end
    endtask

    // Start a walk; optionally pulse start again at busy cycle 'mid'
    task automatic run_shape(input logic [26:0] w, input int mid,
                             input logic [26:0] w2, input string req);
        int blen;
        @(negedge clk);
        shape_cfg_i = w;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        blen = 0;
        while (busy_o && blen < 1000) begin
            blen++;
            if (blen == mid) begin
                shape_cfg_i = w2;
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(blen == 128, "R7", "busy cycles", blen, 128);
        chk(done_o == 1'b1, "R7", "done after busy", done_o, 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R7", "done width", done_o, 0);
        compare_table(req);
    endtask

    task automatic t_reset;
        chk(busy_o == 0 && done_o == 0 && illegal_o == 0, "R1", "flags",
            {busy_o, done_o, illegal_o}, 0);
        chk(offs_o == 3'b000, "R1", "offset flags", offs_o, 0);
        lk_reg_i = 7'd3; lk_mode_i = 2'd0;
        #1;
        chk(lk_hit_o == 0, "R1", "lookup hit", lk_hit_o, 0);
        for (int i = 0; i < 128; i++) exp_tab[i] = 8'd0;
        compare_table("R1");
    endtask

    task automatic t_orders;
        for (int p = 0; p < 6; p++) begin
            build_exp(3, 4, 2, p);
            run_shape(mk(2, 3, 1, 3'b000, p), 0, '0, $sformatf("R3 perm%0d", p));
        end
    endtask

    task automatic t_sizes;
        build_exp(5, 1, 7, 0);
        run_shape(mk(4, 0, 6, 3'b000, 0), 0, '0, "R2");
    endtask

    task automatic t_wrap;
        build_exp(2, 2, 2, 5);
        run_shape(mk(1, 1, 1, 3'b000, 5), 0, '0, "R5 wrap2x2x2");
        build_exp(2, 3, 1, 3);
        run_shape(mk(1, 2, 0, 3'b000, 3), 0, '0, "R5 wrap2x3x1");
    endtask

    task automatic t_trunc;
        build_exp(128, 4, 1, 2);
        run_shape(mk(127, 3, 0, 3'b000, 2), 0, '0, "R4");
        chk(exp_tab[3] == 8'd128, "R4", "model truncation", exp_tab[3], 128);
    endtask

    task automatic t_illegal;
        build_exp(3, 3, 3, 1);
        run_shape(mk(2, 2, 2, 3'b011, 1), 0, '0, "R6 setup");
        for (int p = 6; p < 8; p++) begin
            @(negedge clk);
            shape_cfg_i = mk(0, 0, 0, 3'b100, p);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(illegal_o == 1'b1, "R6", "illegal pulse", illegal_o, 1);
            chk(busy_o == 1'b0, "R6", "busy on fault", busy_o, 0);
            @(negedge clk);
            chk(illegal_o == 1'b0, "R6", "illegal width", illegal_o, 0);
            chk(busy_o == 1'b0, "R6", "busy after fault", busy_o, 0);
            chk(offs_o == 3'b011, "R6", "offsets kept", offs_o, 3);
            compare_table("R6 table kept");
        end
    endtask

    task automatic t_restart_ignored;
        build_exp(4, 2, 3, 4);
        run_shape(mk(3, 1, 2, 3'b000, 4), 40, mk(1, 1, 1, 3'b111, 0), "R8");
        chk(offs_o == 3'b000, "R8", "offsets from first", offs_o, 0);
    endtask

    task automatic t_offsets;
        build_exp(2, 2, 1, 0);
        run_shape(mk(1, 1, 0, 3'b101, 0), 0, '0, "R9 run");
        chk(offs_o == 3'b101, "R9", "offsets 101", offs_o, 5);
        run_shape(mk(1, 1, 0, 3'b010, 0), 0, '0, "R9 run2");
        chk(offs_o == 3'b010, "R9", "offsets 010", offs_o, 2);
    endtask

    task automatic t_lookup;
        remap_cfg_i = {7'd9, 7'd9, 7'd5};
        lk_mode_i = 2'd0; lk_reg_i = 7'd9; #1;
        chk(lk_hit_o == 1 && lk_slot_o == 2'd1, "R11", "first of two",
            {lk_hit_o, lk_slot_o}, 5);
        lk_reg_i = 7'd5; #1;
        chk(lk_hit_o == 1 && lk_slot_o == 2'd0, "R11", "slot0",
            {lk_hit_o, lk_slot_o}, 4);
        lk_reg_i = 7'd12; #1;
        chk(lk_hit_o == 0, "R11", "miss", lk_hit_o, 0);
        remap_cfg_i = {7'd30, 7'd2, 7'd1}; lk_reg_i = 7'd30; #1;
        chk(lk_hit_o == 1 && lk_slot_o == 2'd2, "R11", "slot2",
            {lk_hit_o, lk_slot_o}, 6);
        for (int m = 1; m < 4; m++) begin
            lk_mode_i = 2'(m); #1;
            chk(lk_hit_o == 0, "R10", $sformatf("mode %0d", m), lk_hit_o, 0);
        end
        lk_mode_i = 2'd0;
        remap_cfg_i = {7'd4, 7'd0, 7'd0}; lk_reg_i = 7'd0; #1;
        chk(lk_hit_o == 0, "R10", "register zero", lk_hit_o, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sizes();
        t_orders();
        t_wrap();
        t_trunc();
        t_illegal();
        t_restart_ignored();
        t_offsets();
        t_lookup();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule